// File: doc/BRIEF.md
# Converter Power-Down and Soft-Reset Sequencer

This block sequences power management for a sampling converter that is controlled over a serial link. Each access is a 12-bit word, shifted in most significant bit first, one bit per clock while `sel` is high. A word addressed to the configuration slot sets three low-power enables: deep, nap and auto-nap. The sequencer turns these enables into two bias-enable outputs for the analog section. It also drives start and abort strobes to a small conversion engine, which is a busy/done stub held inside the block. Wake-up delays are counted in clock cycles, and the lengths are set by parameters.

Deep sleep switches off both the core and comparator biases. Nap switches off only the comparator bias. Auto-nap puts the block into nap on its own after every finished conversion. The next convert request wakes the block and launches a conversion after a fixed delay. A word carrying the reset address, sent together with a read strobe, returns the whole block to its initial state. After that reset, the serial port is closed for a set time.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_q` is 000, both bias enables are 1, `pm_ready` is 1, `err_flag` is 0, `cv_busy` is 0 and `sif_ready` is 1.
- R2: A word is 12 bits, sent MSB first. Bits [11:9] are the address. Address 001 writes bit 2 (deep), bit 1 (nap) and bit 0 (auto-nap) into `mode_q`. The write lands on the clock edge that samples the 12th bit, and never earlier.
- R3: One cycle after deep is committed, `core_bias_en`, `cmp_bias_en` and `pm_ready` are all 0.
- R4: One cycle after nap is committed (with deep clear), `cmp_bias_en` and `pm_ready` are 0 while `core_bias_en` stays 1.
- R5: If deep or nap is committed while a conversion is busy, `cv_abort` is high in the cycle after the commit edge, and `cv_busy` is 0 one cycle later.
- R6: When several enables are set, deep wins over nap and nap wins over auto-nap. Clearing deep while nap is still set goes straight to nap.
- R7: Clearing deep keeps `pm_ready` low for DEEP_WAKE_CYC (8) cycles after the state change, and clearing nap keeps it low for NAP_WAKE_CYC (3) cycles. `pm_ready` then returns to 1.
- R8: Entering or leaving a low-power state never alters `mode_q`. Words sent to any address other than 001 leave `mode_q` unchanged.
- R9: With auto-nap set, the end of each conversion clears `cmp_bias_en` on the edge where `cv_busy` falls.
- R10: A convert request in auto-nap sleep raises `cv_start` 6 cycles after the request is sampled. The conversion lasts 13 cycles, so the bias drops again 19 cycles after the request.
- R11: A convert request during deep, nap or any wake-up count starts nothing and sets `err_flag`. `err_flag` stays set until a reset.
- R12: A word with address 101 whose access carries `rd_stb` clears `mode_q`, `err_flag` and any conversion. It also holds `sif_ready` low for LOCK_CYC (125) cycles, and words sent during that time are ignored.
- R13: A word with address 101 sent without `rd_stb` causes no reset and leaves `mode_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit is taken per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Serial access active |
| sdi | input | 1 | Serial data bit, MSB first |
| rd_stb | input | 1 | Read strobe that qualifies a reset word |
| convst | input | 1 | Convert request pulse |
| mode_q | output | 3 | Stored enables {deep, nap, auto-nap} |
| cmp_bias_en | output | 1 | Comparator and mid-buffer bias enable |
| core_bias_en | output | 1 | Core analog bias enable |
| pm_ready | output | 1 | Fully awake and able to convert |
| cv_start | output | 1 | Start strobe to the conversion engine |
| cv_abort | output | 1 | Abort strobe to the conversion engine |
| cv_busy | output | 1 | Conversion in progress |
| err_flag | output | 1 | Sticky flag for a rejected convert request |
| sif_ready | output | 1 | Serial port accepting words |

## Verification
A configuration write appears on `mode_q` at the negedge that follows the edge sampling the 12th bit. The bias outputs and `cv_abort` move one edge after that commit. Wake-up checks count DEEP_WAKE_CYC or NAP_WAKE_CYC further negedges, and a check sits on each side of the edge where `pm_ready` returns. In auto-nap, the bench samples `cv_start` low for five cycles and high on the sixth after the request, and it samples the bias at cycles 18 and 19. The bench checks `sif_ready` on the last locked cycle and on the first free cycle after a soft reset.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [2:0] {
    PS_ACT    = 3'd0,
    PS_DEEP   = 3'd1,
    PS_DWAKE  = 3'd2,
    PS_NAP    = 3'd3,
    PS_NWAKE  = 3'd4,
    PS_ASLEEP = 3'd5,
    PS_AWAKE  = 3'd6
  } pm_state_e;

  localparam logic [2:0] ADDR_CFG = 3'b001;
  localparam logic [2:0] ADDR_RST = 3'b101;

  // Enable bit positions within the stored mode
  localparam int MB_DEEP = 2;
  localparam int MB_NAP  = 1;
  localparam int MB_AUTO = 0;

  // true on the last cycle of an n-cycle count that starts at zero
  function automatic logic cnt_hit(input logic [31:0] c, input int unsigned n);
    return c == 32'(n - 1);
  endfunction

endpackage

// File: rtl/sif_shift.sv
module sif_shift
  import pm_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int LOCK_CYC = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sdi,
  input  logic       rd_stb,
  output logic [2:0] mode_q,
  output logic       word_done,
  output logic       soft_rst,
  output logic       sif_ready
);
  localparam int BC_W = $clog2(WORD_W + 1);
  localparam int LK_W = $clog2(LOCK_CYC + 1);

  logic [WORD_W-2:0] sh_q;
  logic [BC_W-1:0]   bc_q;
  logic [LK_W-1:0]   lock_q;
  logic              rd_pend_q;

  logic              shift_en;
  logic [WORD_W-1:0] word_w;
  logic [2:0]        addr_w;
  logic              cfg_wr;
  logic              unused_bits;

  assign sif_ready   = (lock_q == '0);
  assign shift_en    = sel && sif_ready;
  assign word_w      = {sh_q, sdi};
  assign addr_w      = word_w[WORD_W-1 -: 3];
  assign word_done   = shift_en && (bc_q == BC_W'(WORD_W - 1));
  assign soft_rst    = word_done && (rd_pend_q || rd_stb) && (addr_w == ADDR_RST);
  assign cfg_wr      = word_done && (addr_w == ADDR_CFG);
  assign unused_bits = ^word_w[WORD_W-4:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      bc_q      <= '0;
      lock_q    <= '0;
      rd_pend_q <= 1'b0;
      mode_q    <= '0;
    end else begin
      if (lock_q != '0) lock_q <= lock_q - 1'b1;
      if (shift_en) sh_q <= {sh_q[WORD_W-3:0], sdi};
      if (!shift_en || word_done) bc_q <= '0;
      else                        bc_q <= bc_q + 1'b1;
      if (word_done || !sif_ready) rd_pend_q <= 1'b0;
      else if (rd_stb)             rd_pend_q <= 1'b1;
      if (soft_rst) begin
        mode_q <= '0;
        lock_q <= LK_W'(LOCK_CYC);
      end else if (cfg_wr) begin
        mode_q <= word_w[2:0];
      end
    end
  end

  // R2: stored enables only move on the edge that completes a word
  a_r2_commit_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(word_done));

  // R12: a soft reset closes the serial port on the next cycle
  a_r12_lock_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !sif_ready);

endmodule

// File: rtl/conv_stub.sv
module conv_stub #(
  parameter int CONV_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CC_W = $clog2(CONV_CYC + 1);

  logic [CC_W-1:0] cnt_q;

  assign done = busy && (cnt_q == CC_W'(CONV_CYC - 1)) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: an abort always ends the conversion on the next edge
  a_r5_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R10: a conversion only begins after a start strobe
  a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pm_pkg::*;
#(
  parameter int DEEP_WAKE_CYC = 8,
  parameter int NAP_WAKE_CYC  = 3,
  parameter int AN_START_DLY  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       soft_rst,
  input  logic       convst,
  input  logic       busy,
  input  logic       done,
  output logic       cv_start,
  output logic       cv_abort,
  output logic       cmp_bias_en,
  output logic       core_bias_en,
  output logic       pm_ready,
  output logic       err_flag
);
  localparam int MAX_AB = (DEEP_WAKE_CYC > NAP_WAKE_CYC) ? DEEP_WAKE_CYC : NAP_WAKE_CYC;
  localparam int MAXC   = (MAX_AB > AN_START_DLY) ? MAX_AB : AN_START_DLY;
  localparam int CW     = $clog2(MAXC + 1);

  pm_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic err_q;
  logic go_down, blocked, start_w;
  logic dp, np, an;

  assign dp = mode[MB_DEEP];
  assign np = mode[MB_NAP];
  assign an = mode[MB_AUTO];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    go_down = 1'b0;
    blocked = 1'b0;
    start_w = 1'b0;
    case (st_q)
      PS_ACT: begin
        if (dp)                  begin st_d = PS_DEEP; go_down = 1'b1; end
        else if (np)             begin st_d = PS_NAP;  go_down = 1'b1; end
        else if (convst && !busy) start_w = 1'b1;
        else if (an && done)     st_d = PS_ASLEEP;
      end
      PS_DEEP: begin
        blocked = 1'b1;
        if (!dp) begin
          if (np) st_d = PS_NAP;
          else begin st_d = PS_DWAKE; cnt_d = '0; end
        end
      end
      PS_DWAKE: begin
        blocked = 1'b1;
        if (dp) st_d = PS_DEEP;
        else if (cnt_hit(32'(cnt_q), DEEP_WAKE_CYC)) st_d = PS_ACT;
        else cnt_d = cnt_q + 1'b1;
      end
      PS_NAP: begin
        blocked = 1'b1;
        if (dp) st_d = PS_DEEP;
        else if (!np) begin st_d = PS_NWAKE; cnt_d = '0; end
      end
      PS_NWAKE: begin
        blocked = 1'b1;
        if (dp)      st_d = PS_DEEP;
        else if (np) st_d = PS_NAP;
        else if (cnt_hit(32'(cnt_q), NAP_WAKE_CYC)) st_d = PS_ACT;
        else cnt_d = cnt_q + 1'b1;
      end
      PS_ASLEEP: begin
        if (dp)          st_d = PS_DEEP;
        else if (np)     st_d = PS_NAP;
        else if (!an)    begin st_d = PS_NWAKE; cnt_d = '0; end
        else if (convst) begin st_d = PS_AWAKE; cnt_d = '0; end
      end
      PS_AWAKE: begin
        blocked = 1'b1;
        if (dp)      st_d = PS_DEEP;
        else if (np) st_d = PS_NAP;
        else if (cnt_hit(32'(cnt_q), AN_START_DLY)) begin
          start_w = 1'b1;
          st_d    = PS_ACT;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = PS_ACT;
    endcase
    if (soft_rst) begin
      st_d    = PS_ACT;
      cnt_d   = '0;
      start_w = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_ACT;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (soft_rst)               err_q <= 1'b0;
      else if (blocked && convst) err_q <= 1'b1;
    end
  end

  assign cv_start     = start_w;
  assign cv_abort     = (go_down || soft_rst) && busy;
  assign core_bias_en = (st_q != PS_DEEP);
  assign cmp_bias_en  = !(st_q inside {PS_DEEP, PS_NAP, PS_ASLEEP});
  assign pm_ready     = (st_q == PS_ACT);
  assign err_flag     = err_q;

  // R11: the error flag only clears through a soft reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !$past(soft_rst)) |-> err_q);

  // R7: leaving a wake count always lands fully awake or back asleep
  a_r7_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PS_NWAKE && st_q != PS_NWAKE) |->
      (st_q inside {PS_ACT, PS_DEEP, PS_NAP}));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int WORD_W        = 12,
  parameter int CONV_CYC      = 13,
  parameter int DEEP_WAKE_CYC = 8,
  parameter int NAP_WAKE_CYC  = 3,
  parameter int AN_START_DLY  = 6,
  parameter int LOCK_CYC      = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sdi,
  input  logic       rd_stb,
  input  logic       convst,
  output logic [2:0] mode_q,
  output logic       cmp_bias_en,
  output logic       core_bias_en,
  output logic       pm_ready,
  output logic       cv_start,
  output logic       cv_abort,
  output logic       cv_busy,
  output logic       err_flag,
  output logic       sif_ready
);
  logic word_done;
  logic soft_rst;
  logic cv_done;

  sif_shift #(.WORD_W(WORD_W), .LOCK_CYC(LOCK_CYC)) u_sif (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sdi(sdi), .rd_stb(rd_stb),
    .mode_q(mode_q), .word_done(word_done), .soft_rst(soft_rst),
    .sif_ready(sif_ready)
  );

  pm_fsm #(
    .DEEP_WAKE_CYC(DEEP_WAKE_CYC), .NAP_WAKE_CYC(NAP_WAKE_CYC),
    .AN_START_DLY(AN_START_DLY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .soft_rst(soft_rst),
    .convst(convst), .busy(cv_busy), .done(cv_done),
    .cv_start(cv_start), .cv_abort(cv_abort), .cmp_bias_en(cmp_bias_en),
    .core_bias_en(core_bias_en), .pm_ready(pm_ready), .err_flag(err_flag)
  );

  conv_stub #(.CONV_CYC(CONV_CYC)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(cv_start), .abort(cv_abort),
    .busy(cv_busy), .done(cv_done)
  );

  // R6: deep held for two edges means both biases are off, whatever else is set
  a_r6_deep_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2] && $past(mode_q[2])) |-> (!core_bias_en && !cmp_bias_en));

  // R3: the core bias only drops after deep has been stored
  a_r3_core_off_needs_deep: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_bias_en) |-> $past(mode_q[2]));

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  localparam int DWK  = 8;
  localparam int NWK  = 3;
  localparam int ADLY = 6;
  localparam int CCYC = 13;
  localparam int LCK  = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sdi = 1'b0, rd_stb = 1'b0, convst = 1'b0;
  logic [2:0] mode_q;
  logic cmp_bias_en, core_bias_en, pm_ready, cv_start, cv_abort, cv_busy;
  logic err_flag, sif_ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(
    .WORD_W(12), .CONV_CYC(CCYC), .DEEP_WAKE_CYC(DWK), .NAP_WAKE_CYC(NWK),
    .AN_START_DLY(ADLY), .LOCK_CYC(LCK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sdi(sdi), .rd_stb(rd_stb),
    .convst(convst), .mode_q(mode_q), .cmp_bias_en(cmp_bias_en),
    .core_bias_en(core_bias_en), .pm_ready(pm_ready), .cv_start(cv_start),
    .cv_abort(cv_abort), .cv_busy(cv_busy), .err_flag(err_flag),
    .sif_ready(sif_ready)
  );

  // word: {addr[2:0], 6'b0, deep, nap, auto}; expect: {cmp, core, ready}
  localparam logic [14:0] VEC [7] = '{
    {12'h200, 3'b111},
    {12'h204, 3'b000},
    {12'h206, 3'b000},
    {12'h202, 3'b010},
    {12'h203, 3'b010},
    {12'h200, 3'b110},
    {12'h201, 3'b111}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [11:0] w, input int nb, input bit rd, input bit cv);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      sel    = 1'b1;
      sdi    = w[11-i];
      rd_stb = rd && (i == 0);
      convst = cv && (i == 0);
    end
  endtask

  // returns at the negedge after the edge that took the 12th bit
  task automatic send_word(input logic [11:0] w, input bit rd, input bit cv);
    shift_bits(w, 12, rd, cv);
    @(negedge clk);
    sel = 1'b0; rd_stb = 1'b0; convst = 1'b0;
  endtask

  task automatic pulse_conv();
    @(negedge clk);
    convst = 1'b1;
    @(negedge clk);
    convst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 mode", mode_q, 3'b000);
    chk("R1 bias", {cmp_bias_en, core_bias_en, pm_ready}, 3'b111);
    chk("R1 err", err_flag, 0);
    chk("R1 busy", cv_busy, 0);
    chk("R1 sif", sif_ready, 1);

    // Table: R2 R3 R4 R6 R8
    for (int v = 0; v < 7; v++) begin
      send_word(VEC[v][14:3], 1'b0, 1'b0);
      chk("R2 table mode", mode_q, VEC[v][5:3]);
      cyc(1);
      chk("R3 R4 R6 table bias", {cmp_bias_en, core_bias_en, pm_ready}, VEC[v][2:0]);
      chk("R8 table mode kept", mode_q, VEC[v][5:3]);
    end

    // R2: not committed after 11 bits
    shift_bits(12'h204, 11, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 eleven bits", mode_q, 3'b001);
    sdi = 1'b0;
    @(negedge clk);
    sel = 1'b0;
    chk("R2 twelfth bit", mode_q, 3'b100);
    cyc(1);
    chk("R3 deep bias", {cmp_bias_en, core_bias_en, pm_ready}, 3'b000);

    // R7 deep wake
    send_word(12'h200, 1'b0, 1'b0);
    cyc(DWK);
    chk("R7 deep wake low", pm_ready, 0);
    chk("R7 core back", core_bias_en, 1);
    cyc(1);
    chk("R7 deep wake done", pm_ready, 1);

    // R4 nap, R11 rejected convert
    send_word(12'h202, 1'b0, 1'b0);
    cyc(1);
    chk("R4 nap", {cmp_bias_en, core_bias_en, pm_ready}, 3'b010);
    pulse_conv();
    chk("R11 err set", err_flag, 1);
    chk("R11 no conversion", cv_busy, 0);
    // R7 nap wake
    send_word(12'h200, 1'b0, 1'b0);
    cyc(NWK);
    chk("R7 nap wake low", pm_ready, 0);
    cyc(1);
    chk("R7 nap wake done", pm_ready, 1);
    chk("R11 err sticky", err_flag, 1);

    // R5 abort on nap entry during conversion
    send_word(12'h202, 1'b0, 1'b1);
    chk("R5 abort strobe", cv_abort, 1);
    chk("R5 busy before", cv_busy, 1);
    cyc(1);
    chk("R5 busy cleared", cv_busy, 0);
    chk("R8 mode after nap", mode_q, 3'b010);
    send_word(12'h200, 1'b0, 1'b0);
    cyc(NWK + 2);

    // R9 / R10 auto-nap
    send_word(12'h201, 1'b0, 1'b0);
    cyc(1);
    pulse_conv();
    chk("R9 busy", cv_busy, 1);
    cyc(12);
    chk("R9 still busy", cv_busy, 1);
    cyc(1);
    chk("R9 done", cv_busy, 0);
    chk("R9 autonap bias", cmp_bias_en, 0);
    pulse_conv();
    for (int i = 0; i < ADLY - 1; i++) begin
      chk("R10 start waits", cv_start, 0);
      cyc(1);
    end
    chk("R10 start on sixth", cv_start, 1);
    cyc(1);
    chk("R10 busy", cv_busy, 1);
    cyc(CCYC - 1);
    chk("R10 bias at 18", cmp_bias_en, 1);
    cyc(1);
    chk("R10 bias at 19", cmp_bias_en, 0);
    chk("R8 mode in sleep", mode_q, 3'b001);

    // R12 soft reset
    send_word(12'hA00, 1'b1, 1'b0);
    chk("R12 mode cleared", mode_q, 3'b000);
    chk("R12 err cleared", err_flag, 0);
    chk("R12 awake", pm_ready, 1);
    chk("R12 sif locked", sif_ready, 0);
    send_word(12'h204, 1'b0, 1'b0);
    chk("R12 word ignored", mode_q, 3'b000);
    cyc(LCK - 14);
    chk("R12 last locked", sif_ready, 0);
    cyc(1);
    chk("R12 unlocked", sif_ready, 1);

    // R13 reset address without read strobe
    send_word(12'h202, 1'b0, 1'b0);
    send_word(12'hA00, 1'b0, 1'b0);
    chk("R13 mode kept", mode_q, 3'b010);
    chk("R13 sif open", sif_ready, 1);
    cyc(1);
    chk("R13 still nap", pm_ready, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule